// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Multi-Header Queue

This block keeps the first-error record of an uncorrectable error reporting capability. Each error event brings a one-hot status bit, four header words, four prefix words, a header-valid flag and a prefix-present flag. The block holds the sticky uncorrectable status vector, a pointer to the bit of the error that is currently logged, a header log, a prefix log and a flag that says whether a prefix was logged.

When multiple header recording is switched on, errors that arrive while the logged error's status bit is still set are not allowed to overwrite the log. They wait in a small FIFO instead. When software clears the logged error's status bit with a write-one-to-clear, the oldest waiting error moves into the log. If the FIFO is full, the new error is dropped and a one-cycle pulse is raised so that surrounding logic can report a correctable header-log-overflow error. Decoding of configuration space, error classification and message propagation are handled by other blocks.

All results are registered. They appear on the outputs one clock after the edge that sampled the inputs.

Top module: `err_hdr_log_queue`

## Requirements
- R1: An accepted event (err_valid high, exactly one bit of err_status set at index k) sets uncor_status bit k, whether the event is logged, queued or dropped. When it is logged, first_ptr becomes k.
- R2: An event whose err_status has zero bits or more than one bit set changes neither uncor_status nor any log output.
- R3: While mhr_en is high, mhr_cap is 1 and uncor_status[first_ptr] is set, an accepted event goes to the queue. first_ptr, hdr_log, pfx_log and pfx_logged keep their values.
- R4: An event that must be queued when the queue already holds DEPTH entries is dropped, and hdr_ovf is high for exactly the next cycle.
- R5: When a write leaves uncor_status[first_ptr] clear and either mhr_en is low or the queue is empty, first_ptr, pfx_logged, hdr_log and pfx_log all become zero.
- R6: When an error is loaded into the log with its header-valid flag low, hdr_log reads zero. Otherwise hdr_log holds the four header words, with word 0 in the least significant 32 bits.
- R7: pfx_log holds the prefix words and pfx_logged is 1 only if the loaded error has its prefix flag set and pfx_en is high at the time of loading. In every other case both are zero.
- R8: When a write clears uncor_status[first_ptr] while mhr_en is high and entries are queued, the oldest entry is loaded into the log. The status bits of that entry and of every entry still queued are set again, so queued errors come out in arrival order.
- R9: A write that leaves uncor_status[first_ptr] set re-asserts every queued error's status bit when mhr_en is high. When mhr_en is low, the same write empties the queue instead.
- R10: mhr_cap is 1 exactly when DEPTH > 0. With DEPTH = 0, mhr_en has no effect and every accepted event overwrites the log.
- R11: When a clear write and an event arrive in the same cycle, the write is applied first and the event is then handled against the state that results.
- R12: uncor_status bits are only cleared by clr_en writes. Without a write, no set bit drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mhr_en | input | 1 | Multiple header recording enable |
| pfx_en | input | 1 | End-to-end prefix logging enable |
| err_valid | input | 1 | Error event strobe |
| err_status | input | STAT_W | One-hot uncorrectable status bit of the event |
| err_hdr_ok | input | 1 | Event header words are valid |
| err_hdr | input | WORD_W*LOG_WORDS | Event header words, word 0 in the low bits |
| err_pfx_ok | input | 1 | Event carries prefix words |
| err_pfx | input | WORD_W*LOG_WORDS | Event prefix words, word 0 in the low bits |
| clr_en | input | 1 | Write-one-to-clear strobe for the status vector |
| clr_mask | input | STAT_W | Status bits to clear |
| uncor_status | output | STAT_W | Sticky uncorrectable status vector |
| first_ptr | output | $clog2(STAT_W) | Bit index of the logged error |
| pfx_logged | output | 1 | Prefix log holds valid prefix words |
| hdr_log | output | WORD_W*LOG_WORDS | Header log |
| pfx_log | output | WORD_W*LOG_WORDS | Prefix log |
| hdr_ovf | output | 1 | One-cycle pulse: an error was dropped because the queue was full |
| mhr_cap | output | 1 | Multiple header recording capability |

## Verification
Every result of an event or a clear write is due one clock edge after the inputs are sampled: the status vector, the pointer, both logs and the overflow pulse. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. The overflow pulse is checked at that sample and again one cycle later to confirm it has dropped. Promotion order is tested by draining the full queue one clear at a time. Each clear is followed by a check of the pointer and the header that came up.

// File: rtl/err_hdr_log_queue.sv
module err_hdr_log_queue #(
  parameter int STAT_W    = 32,
  parameter int WORD_W    = 32,
  parameter int LOG_WORDS = 4,
  parameter int DEPTH     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mhr_en,
  input  logic                          pfx_en,
  input  logic                          err_valid,
  input  logic [STAT_W-1:0]             err_status,
  input  logic                          err_hdr_ok,
  input  logic [WORD_W*LOG_WORDS-1:0]   err_hdr,
  input  logic                          err_pfx_ok,
  input  logic [WORD_W*LOG_WORDS-1:0]   err_pfx,
  input  logic                          clr_en,
  input  logic [STAT_W-1:0]             clr_mask,
  output logic [STAT_W-1:0]             uncor_status,
  output logic [$clog2(STAT_W)-1:0]     first_ptr,
  output logic                          pfx_logged,
  output logic [WORD_W*LOG_WORDS-1:0]   hdr_log,
  output logic [WORD_W*LOG_WORDS-1:0]   pfx_log,
  output logic                          hdr_ovf,
  output logic                          mhr_cap
);
  localparam int   PTR_W = $clog2(STAT_W);
  localparam int   LOG_W = WORD_W * LOG_WORDS;
  localparam int   SLOTS = (DEPTH > 0) ? DEPTH : 1;
  localparam int   CNT_W = $clog2(SLOTS + 1);
  localparam logic HAS_Q = (DEPTH > 0);

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic              hdr_ok;
    logic [LOG_W-1:0]  hdr;
    logic              pfx_ok;
    logic [LOG_W-1:0]  pfx;
  } rec_t;

  typedef struct packed {
    logic [PTR_W-1:0] fp;
    logic             pflag;
    logic [LOG_W-1:0] hl;
    logic [LOG_W-1:0] pl;
  } log_t;

  function automatic logic [PTR_W-1:0] bit_idx(logic [STAT_W-1:0] s);
    logic [PTR_W-1:0] r = '0;
    for (int i = 0; i < STAT_W; i++)
      if (s[i]) r = PTR_W'(i);
    return r;
  endfunction

  function automatic log_t fill(rec_t r, logic pen);
    log_t l;
    l.fp    = bit_idx(r.stat);
    l.hl    = r.hdr_ok ? r.hdr : '0;
    l.pflag = r.pfx_ok & pen;
    l.pl    = l.pflag ? r.pfx : '0;
    return l;
  endfunction

  logic [STAT_W-1:0] st, st_n, q_or;
  log_t              lg, lg_n;
  rec_t              q   [SLOTS];
  rec_t              q_n [SLOTS];
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              ovf, ovf_n;
  logic              mhr_act, ev_ok;
  rec_t              ev;

  assign mhr_act = mhr_en & HAS_Q;
  assign ev_ok   = err_valid && $onehot(err_status);
  assign ev      = '{err_status, err_hdr_ok, err_hdr, err_pfx_ok, err_pfx};

  always_comb begin
    q_or = '0;
    for (int i = 0; i < SLOTS; i++)
      if (CNT_W'(i) < cnt) q_or = q_or | q[i].stat;
  end

  always_comb begin
    st_n  = st;
    lg_n  = lg;
    q_n   = q;
    cnt_n = cnt;
    ovf_n = 1'b0;
    if (clr_en) begin
      st_n = st & ~clr_mask;
      if (!st_n[lg.fp]) begin
        if (!mhr_act || cnt == '0) begin
          lg_n = '0;
        end else begin
          st_n = st_n | q_or;
          lg_n = fill(q[0], pfx_en);
          for (int i = 0; i < SLOTS - 1; i++) q_n[i] = q[i+1];
          cnt_n = cnt - CNT_W'(1);
        end
      end else if (mhr_act) begin
        st_n = st_n | q_or;
      end else begin
        cnt_n = '0;
      end
    end
    if (ev_ok) begin
      if (mhr_act && st_n[lg_n.fp]) begin
        if (cnt_n == CNT_W'(SLOTS)) begin
          ovf_n = 1'b1;
        end else begin
          for (int i = 0; i < SLOTS; i++)
            if (CNT_W'(i) == cnt_n) q_n[i] = ev;
          cnt_n = cnt_n + CNT_W'(1);
        end
      end else begin
        lg_n = fill(ev, pfx_en);
      end
      st_n = st_n | err_status;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= '0;
      lg  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      for (int i = 0; i < SLOTS; i++) q[i] <= '0;
    end else begin
      st  <= st_n;
      lg  <= lg_n;
      cnt <= cnt_n;
      ovf <= ovf_n;
      for (int i = 0; i < SLOTS; i++) q[i] <= q_n[i];
    end
  end

  assign uncor_status = st;
  assign first_ptr    = lg.fp;
  assign pfx_logged   = lg.pflag;
  assign hdr_log      = lg.hl;
  assign pfx_log      = lg.pl;
  assign hdr_ovf      = ovf;
  assign mhr_cap      = HAS_Q;
endmodule

// File: rtl/err_hdr_log_queue_chk.sv
module err_hdr_log_queue_chk #(
  parameter int STAT_W = 32,
  parameter int LOG_W  = 128
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mhr_en,
  input logic                      err_valid,
  input logic [STAT_W-1:0]         err_status,
  input logic                      err_hdr_ok,
  input logic [LOG_W-1:0]          err_hdr,
  input logic                      clr_en,
  input logic [STAT_W-1:0]         clr_mask,
  input logic [STAT_W-1:0]         uncor_status,
  input logic [$clog2(STAT_W)-1:0] first_ptr,
  input logic                      pfx_logged,
  input logic [LOG_W-1:0]          hdr_log,
  input logic [LOG_W-1:0]          pfx_log,
  input logic                      hdr_ovf,
  input logic                      mhr_cap
);
  a_r1_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $countones(err_status) == 1 && !clr_en)
      |=> ((uncor_status & $past(err_status)) == $past(err_status)));

  a_r2_bad_event_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $countones(err_status) != 1 && !clr_en)
      |=> ($stable(uncor_status) && $stable(hdr_log) && $stable(first_ptr)));

  a_r3_queued_keeps_log: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $countones(err_status) == 1 && !clr_en && mhr_en && mhr_cap
     && uncor_status[first_ptr])
      |=> ($stable(hdr_log) && $stable(pfx_log) && $stable(first_ptr) && $stable(pfx_logged)));

  a_r4_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ovf |-> $past(err_valid && mhr_en && mhr_cap));

  a_r5_log_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !err_valid && clr_mask[first_ptr] && (!mhr_en || !mhr_cap))
      |=> (first_ptr == '0 && hdr_log == '0 && pfx_log == '0 && !pfx_logged));

  a_r6_header_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $countones(err_status) == 1 && !clr_en
     && !(mhr_en && mhr_cap && uncor_status[first_ptr]))
      |=> (hdr_log == $past(err_hdr_ok ? err_hdr : {LOG_W{1'b0}})));

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((uncor_status & $past(uncor_status)) == $past(uncor_status)));
endmodule

bind err_hdr_log_queue err_hdr_log_queue_chk #(
  .STAT_W(STAT_W), .LOG_W(WORD_W * LOG_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .err_valid(err_valid),
  .err_status(err_status), .err_hdr_ok(err_hdr_ok), .err_hdr(err_hdr),
  .clr_en(clr_en), .clr_mask(clr_mask), .uncor_status(uncor_status),
  .first_ptr(first_ptr), .pfx_logged(pfx_logged), .hdr_log(hdr_log),
  .pfx_log(pfx_log), .hdr_ovf(hdr_ovf), .mhr_cap(mhr_cap)
);

// File: tb/tb_err_hdr_log_queue.sv
module tb_err_hdr_log_queue;
  localparam int SW = 32;
  localparam int LW = 128;

  logic clk = 0, rst_n = 0;
  logic mhr_en = 0, pfx_en = 0, err_valid = 0, err_hdr_ok = 0, err_pfx_ok = 0, clr_en = 0;
  logic [SW-1:0] err_status = '0, clr_mask = '0;
  logic [LW-1:0] err_hdr = '0, err_pfx = '0;
  logic [SW-1:0] st_a, st_b;
  logic [4:0]    fp_a, fp_b;
  logic          pl_a, pl_b, ovf_a, ovf_b, cap_a, cap_b;
  logic [LW-1:0] hl_a, hl_b, xl_a, xl_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  err_hdr_log_queue #(.DEPTH(3)) dut (
    .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .pfx_en(pfx_en), .err_valid(err_valid),
    .err_status(err_status), .err_hdr_ok(err_hdr_ok), .err_hdr(err_hdr),
    .err_pfx_ok(err_pfx_ok), .err_pfx(err_pfx), .clr_en(clr_en), .clr_mask(clr_mask),
    .uncor_status(st_a), .first_ptr(fp_a), .pfx_logged(pl_a), .hdr_log(hl_a),
    .pfx_log(xl_a), .hdr_ovf(ovf_a), .mhr_cap(cap_a));

  err_hdr_log_queue #(.DEPTH(0)) dut_nq (
    .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .pfx_en(pfx_en), .err_valid(err_valid),
    .err_status(err_status), .err_hdr_ok(err_hdr_ok), .err_hdr(err_hdr),
    .err_pfx_ok(err_pfx_ok), .err_pfx(err_pfx), .clr_en(clr_en), .clr_mask(clr_mask),
    .uncor_status(st_b), .first_ptr(fp_b), .pfx_logged(pl_b), .hdr_log(hl_b),
    .pfx_log(xl_b), .hdr_ovf(ovf_b), .mhr_cap(cap_b));

  function automatic logic [LW-1:0] hp(int k);
    return {32'hC0DE0000 | k, 32'h22220000 | k, 32'h11110000 | k, 32'h5A5A0000 | k};
  endfunction
  function automatic logic [LW-1:0] pp(int k);
    return ~hp(k);
  endfunction
  function automatic logic [SW-1:0] bt(int k);
    return SW'(1) << k;
  endfunction

  task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [SW-1:0] s, input logic hok, input logic pok, input int k);
    err_valid = 1; err_status = s; err_hdr_ok = hok; err_hdr = hp(k);
    err_pfx_ok = pok; err_pfx = pp(k);
    @(negedge clk);
    err_valid = 0; err_status = '0;
  endtask

  task automatic clr(input logic [SW-1:0] m);
    clr_en = 1; clr_mask = m;
    @(negedge clk);
    clr_en = 0; clr_mask = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", LW'(st_a), '0);
    check("R5 reset ptr", LW'(fp_a), '0);
    check("R6 reset hdr", hl_a, '0);
    check("R4 reset ovf", LW'(ovf_a), '0);
    check("R10 cap depth3", LW'(cap_a), 1);
    check("R10 cap depth0", LW'(cap_b), 0);

    // R1 R6: sweep every status bit, header valid on odd bits
    for (int b = 0; b < SW; b++) begin
      ev(bt(b), b[0], 1'b1, b);
      check("R1 sweep ptr", LW'(fp_a), LW'(b));
      check("R1 sweep status", LW'(st_a), LW'((b == SW-1) ? {SW{1'b1}} : ((bt(b+1)) - 1)));
      check("R6 sweep hdr", hl_a, b[0] ? hp(b) : '0);
      check("R7 pfx off", xl_a, '0);
    end
    // R2: malformed events
    ev(32'h0000_0003, 1'b1, 1'b0, 40);
    check("R2 two bits status", LW'(st_a), LW'({SW{1'b1}}));
    check("R2 two bits log", hl_a, hp(31));
    ev(32'h0, 1'b1, 1'b0, 41);
    check("R2 zero ptr", LW'(fp_a), 31);
    clr({SW{1'b1}});
    check("R5 clear status", LW'(st_a), '0);
    check("R5 clear ptr", LW'(fp_a), '0);
    check("R5 clear hdr", hl_a, '0);

    // R7 prefix rules
    pfx_en = 1;
    ev(bt(3), 1'b1, 1'b1, 3);
    check("R7 pfx logged", xl_a, pp(3));
    check("R7 pfx flag", LW'(pl_a), 1);
    ev(bt(4), 1'b1, 1'b0, 4);
    check("R7 no pfx", xl_a, '0);
    check("R7 no pfx flag", LW'(pl_a), 0);
    pfx_en = 0;
    ev(bt(5), 1'b1, 1'b1, 5);
    check("R7 pfx disabled", xl_a, '0);
    pfx_en = 1;
    ev(bt(6), 1'b1, 1'b1, 6);
    check("R7 pfx again", LW'(pl_a), 1);
    clr({SW{1'b1}});
    check("R5 pfx flag cleared", LW'(pl_a), 0);
    check("R5 pfx log cleared", xl_a, '0);
    pfx_en = 0;

    // R3 R4 R8 R9: queue fill, overflow, undo, drain
    mhr_en = 1;
    ev(bt(5), 1'b1, 1'b0, 5);
    check("R1 first logged", LW'(fp_a), 5);
    ev(bt(7), 1'b1, 1'b0, 7);
    ev(bt(9), 1'b0, 1'b0, 9);
    ev(bt(11), 1'b1, 1'b0, 11);
    check("R3 log kept", hl_a, hp(5));
    check("R3 ptr kept", LW'(fp_a), 5);
    check("R4 no ovf yet", LW'(ovf_a), 0);
    ev(bt(13), 1'b1, 1'b0, 13);
    check("R4 ovf pulse", LW'(ovf_a), 1);
    check("R1 dropped still sets", LW'(st_a), LW'(bt(5)|bt(7)|bt(9)|bt(11)|bt(13)));
    @(negedge clk);
    check("R4 ovf one cycle", LW'(ovf_a), 0);
    clr(bt(7) | bt(13));
    check("R9 undo queued bits", LW'(st_a), LW'(bt(5)|bt(7)|bt(9)|bt(11)));
    check("R9 ptr unchanged", LW'(fp_a), 5);
    clr(bt(5));
    check("R8 promote ptr", LW'(fp_a), 7);
    check("R8 promote hdr", hl_a, hp(7));
    check("R8 status", LW'(st_a), LW'(bt(7)|bt(9)|bt(11)));
    clr(bt(7));
    check("R8 second ptr", LW'(fp_a), 9);
    check("R6 promoted invalid hdr", hl_a, '0);
    clr(bt(9));
    check("R8 third ptr", LW'(fp_a), 11);
    check("R8 third hdr", hl_a, hp(11));
    clr(bt(11));
    check("R5 drained ptr", LW'(fp_a), 0);
    check("R5 drained hdr", hl_a, '0);
    check("R5 drained status", LW'(st_a), 0);

    // R9: flush when recording disabled
    ev(bt(2), 1'b1, 1'b0, 2);
    ev(bt(3), 1'b1, 1'b0, 3);
    mhr_en = 0;
    clr(bt(3));
    check("R9 flush status", LW'(st_a), LW'(bt(2)));
    mhr_en = 1;
    clr(bt(2));
    check("R9 flushed ptr", LW'(fp_a), 0);
    check("R9 flushed hdr", hl_a, '0);

    // R11: write and event together
    ev(bt(1), 1'b1, 1'b0, 1);
    ev(bt(4), 1'b1, 1'b0, 4);
    clr_en = 1; clr_mask = bt(1);
    ev(bt(6), 1'b1, 1'b0, 6);
    clr_en = 0; clr_mask = '0;
    check("R11 ptr after joint", LW'(fp_a), 4);
    check("R11 status after joint", LW'(st_a), LW'(bt(4)|bt(6)));
    clr(bt(4));
    check("R11 queued event promoted", LW'(fp_a), 6);
    check("R11 queued hdr", hl_a, hp(6));
    clr({SW{1'b1}});

    // R10: no queue ignores mhr_en
    ev(bt(8), 1'b1, 1'b0, 8);
    ev(bt(10), 1'b1, 1'b0, 10);
    check("R10 depth0 overwrite ptr", LW'(fp_b), 10);
    check("R10 depth0 overwrite hdr", hl_b, hp(10));
    check("R10 depth0 no ovf", LW'(ovf_b), 0);
    check("R3 depth3 queued", LW'(fp_a), 8);

    // R12: no write, no clear
    repeat (3) @(negedge clk);
    check("R12 sticky", LW'(st_a), LW'(bt(8)|bt(10)));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule